// File: doc/BRIEF.md
# Fault Response Mode Controller

This block decides how a switching converter reacts to each kind of fault. A 16-bit configuration register holds one bit per fault source. When a fault appears while the converter is running or soft-starting, that bit chooses one of two reactions:

- **Timed auto-restart.** Switching stops, a restart timer runs, and then a new soft-start begins. This repeats for as long as the fault is present.
- **Sticky shutdown.** Switching stops and stays stopped until the enable input is taken low and then high again, or until power-on reset.

The reset value of the low ten register bits comes from a strap pin, so a board can pick either reaction for every fault without software.

The register port is a plain strobe-and-data write with a read bus that is always driven. A write completes in a single cycle and is never refused for lack of space, so the port has no back-pressure. The only thing that can block a write is the write-protect pin.

The fault inputs, the soft-start-done flag and the enable pin are level inputs sampled on every clock. The switching-enable, soft-start-request and fault-status outputs come from registers. Fault status stays readable while the converter is shut down, so the cause of the shutdown can be found afterwards.

Top module: `fault_resp_ctrl`

## Requirements
- R1: While `por_n` is low, `cfg_rdata` resets to 0x03FF if `strap_hic` is 1 and to 0x0000 if it is 0. `sw_en`, `ss_req` and `fault_status` reset to 0.
- R2: When `cfg_wr`=1 and `cfg_wp`=0, all 16 bits of `cfg_wdata` are stored at the clock edge, including bits 15:10. `cfg_rdata` always shows the stored value.
- R3: When `cfg_wp`=1, a write strobe leaves `cfg_rdata` unchanged.
- R4: Fault input `fault_in[i]` is governed by register bit i+2, where 1 selects auto-restart and 0 selects shutdown. Register bits 1:0 have no effect on any fault.
- R5: A rising edge on `en` (low in one cycle, high in the next) starts soft-start on the following edge, with `sw_en`=1 and `ss_req`=1. While in soft-start, `ss_done`=1 moves the block to run (`sw_en`=1, `ss_req`=0). `ss_req` is never 1 while `sw_en` is 0.
- R6: If every active fault selects auto-restart during soft-start or run, `sw_en` is 0 after the next edge. It stays 0 for exactly RESTART_TICKS samples, and then soft-start resumes. If the fault is still present, the sequence repeats.
- R7: After a shutdown, `sw_en` stays 0 whatever the fault inputs do, for as long as `en` stays high. Only a new enable rising edge or a power-on reset restarts the converter.
- R8: If any active fault selects shutdown, the block shuts down, even if other active faults select auto-restart. This also applies when such a fault appears during the restart wait.
- R9: `fault_status` bit i is set for every `fault_in[i]` seen during soft-start, run or restart wait. The bit stays set through shutdown and idle, and is cleared on an enable rising edge.
- R10: If `en` is low at an edge, `sw_en` and `ss_req` are 0 after that edge, whatever state the block was in.
- R11: When a register write and a fault trip fall in the same cycle, the reaction is chosen from the register value as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| strap_hic | input | 1 | Strap level that selects the reset default of bits 9:0 |
| en | input | 1 | Converter enable level |
| cfg_wp | input | 1 | Write protect for the configuration register |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Current register value |
| fault_in | input | 6 | Fault flags: input overvoltage, over-temperature, input average overcurrent, peak overcurrent, output undervoltage, output overvoltage |
| ss_done | input | 1 | Soft-start finished flag |
| sw_en | output | 1 | Switching enable |
| ss_req | output | 1 | Soft-start request |
| fault_status | output | 6 | Sticky record of the faults seen |

## Verification
A configuration write and a fault trip can happen in the same clock cycle. The bench provokes this while the converter is running. In one cycle it clears the auto-restart bit of a fault and also raises that same fault. It then checks that the block enters the timed restart wait, which is the old setting, rather than shutting down. It also checks that the new value is already on `cfg_rdata` after that edge. After the restart, the same fault is raised again, and it must now cause a sticky shutdown.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_HWAIT = 3'd3,
    ST_LATCH = 3'd4
  } frc_state_e;
endpackage

// File: rtl/frc_cfg_reg.sv
module frc_cfg_reg #(
  parameter int REG_W   = 16,
  parameter int DEF_W   = 10
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             strap_hic,
  input  logic             wp,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] reset_val;

  // low DEF_W bits follow the strap, the rest reset to zero
  genvar gi;
  generate
    for (gi = 0; gi < REG_W; gi++) begin : g_def
      if (gi < DEF_W) begin : g_strap
        assign reset_val[gi] = strap_hic;
      end else begin : g_zero
        assign reset_val[gi] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      reg_q <= reset_val;
    else if (wr && !wp)
      reg_q <= wdata;
  end

  assign rdata = reg_q;
endmodule

// File: rtl/frc_fault_eval.sv
module frc_fault_eval #(
  parameter int NUM_FAULTS = 6
) (
  input  logic [NUM_FAULTS-1:0] fault_in,
  input  logic [NUM_FAULTS-1:0] hic_sel,
  output logic                  any_fault,
  output logic                  any_latch
);
  logic [NUM_FAULTS-1:0] latch_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FAULTS; gi++) begin : g_src
      assign latch_hit[gi] = fault_in[gi] && !hic_sel[gi];
    end
  endgenerate

  assign any_fault = |fault_in;
  assign any_latch = |latch_hit;
endmodule

// File: rtl/frc_en_detect.sv
module frc_en_detect (
  input  logic clk,
  input  logic por_n,
  input  logic en,
  output logic en_rise
);
  logic en_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign en_rise = en && !en_q;
endmodule

// File: rtl/frc_seq.sv
module frc_seq
  import frc_pkg::*;
#(
  parameter int NUM_FAULTS    = 6,
  parameter int RESTART_TICKS = 62_500_000,
  localparam int CNT_W = (RESTART_TICKS < 2) ? 1 : $clog2(RESTART_TICKS)
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  en,
  input  logic                  en_rise,
  input  logic                  ss_done,
  input  logic                  any_fault,
  input  logic                  any_latch,
  input  logic [NUM_FAULTS-1:0] fault_in,
  output frc_state_e            state,
  output logic [NUM_FAULTS-1:0] status
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESTART_TICKS - 1);

  frc_state_e            state_q, state_d;
  logic [CNT_W-1:0]      cnt_q;
  logic [NUM_FAULTS-1:0] status_q;
  logic                  active;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (en_rise) state_d = ST_SOFT;
      ST_SOFT: begin
        if (any_latch)      state_d = ST_LATCH;
        else if (any_fault) state_d = ST_HWAIT;
        else if (ss_done)   state_d = ST_RUN;
      end
      ST_RUN: begin
        if (any_latch)      state_d = ST_LATCH;
        else if (any_fault) state_d = ST_HWAIT;
      end
      ST_HWAIT: begin
        if (any_latch)              state_d = ST_LATCH;
        else if (cnt_q == CNT_LAST) state_d = ST_SOFT;
      end
      ST_LATCH: state_d = ST_LATCH;
      default:  state_d = ST_IDLE;
    endcase
    if (!en) state_d = ST_IDLE;
  end

  assign active = (state_q == ST_SOFT) || (state_q == ST_RUN) || (state_q == ST_HWAIT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      status_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_q == ST_HWAIT) ? cnt_q + 1'b1 : '0;
      if (en_rise)     status_q <= '0;
      else if (active) status_q <= status_q | fault_in;
    end
  end

  assign state  = state_q;
  assign status = status_q;
endmodule

// File: rtl/fault_resp_ctrl.sv
module fault_resp_ctrl
  import frc_pkg::*;
#(
  parameter int REG_W         = 16,
  parameter int DEF_W         = 10,
  parameter int NUM_FAULTS    = 6,
  parameter int FAULT_BASE    = 2,
  parameter int RESTART_TICKS = 62_500_000
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  strap_hic,
  input  logic                  en,
  input  logic                  cfg_wp,
  input  logic                  cfg_wr,
  input  logic [REG_W-1:0]      cfg_wdata,
  output logic [REG_W-1:0]      cfg_rdata,
  input  logic [NUM_FAULTS-1:0] fault_in,
  input  logic                  ss_done,
  output logic                  sw_en,
  output logic                  ss_req,
  output logic [NUM_FAULTS-1:0] fault_status
);
  logic [REG_W-1:0] reg_val;
  logic             any_fault, any_latch, en_rise;
  frc_state_e       seq_state;

  frc_cfg_reg #(.REG_W(REG_W), .DEF_W(DEF_W)) u_reg (
    .clk(clk), .por_n(por_n), .strap_hic(strap_hic),
    .wp(cfg_wp), .wr(cfg_wr), .wdata(cfg_wdata), .rdata(reg_val)
  );

  frc_fault_eval #(.NUM_FAULTS(NUM_FAULTS)) u_eval (
    .fault_in(fault_in),
    .hic_sel(reg_val[FAULT_BASE +: NUM_FAULTS]),
    .any_fault(any_fault),
    .any_latch(any_latch)
  );

  frc_en_detect u_en (
    .clk(clk), .por_n(por_n), .en(en), .en_rise(en_rise)
  );

  frc_seq #(.NUM_FAULTS(NUM_FAULTS), .RESTART_TICKS(RESTART_TICKS)) u_seq (
    .clk(clk), .por_n(por_n), .en(en), .en_rise(en_rise), .ss_done(ss_done),
    .any_fault(any_fault), .any_latch(any_latch), .fault_in(fault_in),
    .state(seq_state), .status(fault_status)
  );

  assign cfg_rdata = reg_val;
  assign sw_en     = (seq_state == ST_SOFT) || (seq_state == ST_RUN);
  assign ss_req    = (seq_state == ST_SOFT);
endmodule

// File: rtl/frc_checker.sv
module frc_checker
  import frc_pkg::*;
#(
  parameter int REG_W      = 16,
  parameter int NUM_FAULTS = 6
) (
  input logic                  clk,
  input logic                  por_n,
  input logic                  en,
  input logic                  en_rise,
  input logic                  cfg_wp,
  input logic                  cfg_wr,
  input logic [REG_W-1:0]      cfg_wdata,
  input logic [REG_W-1:0]      cfg_rdata,
  input logic                  any_latch,
  input frc_state_e            seq_state,
  input logic                  sw_en,
  input logic                  ss_req,
  input logic [NUM_FAULTS-1:0] fault_status
);
  assert_wr_take_R2: assert property (@(posedge clk) disable iff (!por_n)
    cfg_wr && !cfg_wp |=> cfg_rdata == $past(cfg_wdata));

  assert_wp_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    cfg_wr && cfg_wp |=> $stable(cfg_rdata));

  assert_ss_needs_sw_R5: assert property (@(posedge clk) disable iff (!por_n)
    ss_req |-> sw_en);

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    (seq_state == ST_LATCH) && en |=> (seq_state == ST_LATCH) && !sw_en);

  assert_latch_trip_R8: assert property (@(posedge clk) disable iff (!por_n)
    (seq_state == ST_RUN || seq_state == ST_SOFT || seq_state == ST_HWAIT) && en && any_latch
    |=> seq_state == ST_LATCH);

  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
    en_rise |=> fault_status == '0);

  assert_en_low_off_R10: assert property (@(posedge clk) disable iff (!por_n)
    !en |=> !sw_en && !ss_req);
endmodule

bind fault_resp_ctrl frc_checker #(.REG_W(REG_W), .NUM_FAULTS(NUM_FAULTS)) u_chk (
  .clk(clk), .por_n(por_n), .en(en), .en_rise(en_rise), .cfg_wp(cfg_wp),
  .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .any_latch(any_latch), .seq_state(seq_state), .sw_en(sw_en),
  .ss_req(ss_req), .fault_status(fault_status)
);

// File: tb/fault_resp_ctrl_test.sv
`timescale 1ns/1ps
module fault_resp_ctrl_test;
  localparam int T = 8;

  typedef struct {
    logic        sw;
    logic        ss;
    logic [5:0]  st;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        por_n, strap_hic, en, cfg_wp, cfg_wr, ss_done;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic [5:0]  fault_in, fault_status;
  logic        sw_en, ss_req;

  exp_t        q[$];
  logic [15:0] cur_rd;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  fault_resp_ctrl #(.RESTART_TICKS(T)) uut (
    .clk(clk), .por_n(por_n), .strap_hic(strap_hic), .en(en),
    .cfg_wp(cfg_wp), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fault_in(fault_in), .ss_done(ss_done), .sw_en(sw_en), .ss_req(ss_req),
    .fault_status(fault_status)
  );

  // driver: push what the outputs must show after the coming edge
  task automatic expect_next(input logic sw, input logic ss, input logic [5:0] st,
                             input string tag);
    exp_t it;
    it.sw = sw; it.ss = ss; it.st = st; it.rd = cur_rd; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic off_for(input int n, input logic [5:0] st, input string tag);
    for (int i = 0; i < n; i++) expect_next(1'b0, 1'b0, st, tag);
  endtask

  task automatic do_por(input logic strap);
    por_n = 1'b0; strap_hic = strap;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    cur_rd = strap ? 16'h03FF : 16'h0000;
  endtask

  // monitor
  initial begin
    forever begin
      exp_t it;
      wait (q.size() != 0);
      @(negedge clk);
      it = q.pop_front();
      total++;
      if (sw_en !== it.sw || ss_req !== it.ss || fault_status !== it.st || cfg_rdata !== it.rd) begin
        bad++;
        $display("FAIL %s: got sw=%b ss=%b st=%h rd=%h, want sw=%b ss=%b st=%h rd=%h",
                 it.tag, sw_en, ss_req, fault_status, cfg_rdata, it.sw, it.ss, it.st, it.rd);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    en = 0; cfg_wp = 0; cfg_wr = 0; cfg_wdata = '0; fault_in = '0; ss_done = 0;
    strap_hic = 1; por_n = 0;
    @(negedge clk);
    do_por(1'b1);
    expect_next(0, 0, 6'h00, "R1 reset strap high");

    en = 1;  expect_next(1, 1, 6'h00, "R5 soft-start on rise");
    en = 1;  expect_next(1, 1, 6'h00, "R5 stay soft");
    ss_done = 1; expect_next(1, 0, 6'h00, "R5 run");

    fault_in = 6'h01; expect_next(0, 0, 6'h01, "R6 hiccup stop");
    fault_in = 6'h00; off_for(T-1, 6'h01, "R6 wait off");
    expect_next(1, 1, 6'h01, "R6 restart soft");
    expect_next(1, 0, 6'h01, "R6 run again");

    fault_in = 6'h01; expect_next(0, 0, 6'h01, "R6 persistent stop");
    off_for(T-1, 6'h01, "R6 persistent wait");
    expect_next(1, 1, 6'h01, "R6 retry soft");
    expect_next(0, 0, 6'h01, "R6 repeat stop");
    fault_in = 6'h00; off_for(T-1, 6'h01, "R6 second wait");
    expect_next(1, 1, 6'h01, "R6 soft");
    expect_next(1, 0, 6'h01, "R6 run");

    // same-cycle write and trip
    cfg_wr = 1; cfg_wdata = 16'h03FB; fault_in = 6'h01; cur_rd = 16'h03FB;
    expect_next(0, 0, 6'h01, "R11 old mode used");
    cfg_wr = 0; fault_in = 6'h00; off_for(T-1, 6'h01, "R11 wait");
    expect_next(1, 1, 6'h01, "R11 soft");
    expect_next(1, 0, 6'h01, "R11 run");

    fault_in = 6'h01; expect_next(0, 0, 6'h01, "R11 new mode latches");
    fault_in = 6'h00; off_for(T+4, 6'h01, "R7 stays off");
    en = 0; expect_next(0, 0, 6'h01, "R9 status held");
    en = 1; expect_next(1, 1, 6'h00, "R9 cleared R7 restart");
    expect_next(1, 0, 6'h00, "R7 run");

    fault_in = 6'h03; expect_next(0, 0, 6'h03, "R8 mixed latches");
    fault_in = 6'h00; off_for(T+2, 6'h03, "R8 stays off");
    en = 0; expect_next(0, 0, 6'h03, "R10 idle");
    en = 1; expect_next(1, 1, 6'h00, "R5 restart");
    expect_next(1, 0, 6'h00, "R5 run");
    fault_in = 6'h02; expect_next(0, 0, 6'h02, "R8 hiccup entry");
    fault_in = 6'h01; expect_next(0, 0, 6'h03, "R8 latch in wait");
    fault_in = 6'h00; off_for(T+2, 6'h03, "R8 latched");

    cfg_wp = 1; cfg_wr = 1; cfg_wdata = 16'hFFFF;
    expect_next(0, 0, 6'h03, "R3 protected");
    cfg_wp = 0; cfg_wdata = 16'hA403; cur_rd = 16'hA403;
    expect_next(0, 0, 6'h03, "R2 full write");
    cfg_wr = 0;
    en = 0; expect_next(0, 0, 6'h03, "R10 idle");
    en = 1; expect_next(1, 1, 6'h00, "R5 restart");
    expect_next(1, 0, 6'h00, "R5 run");
    fault_in = 6'h01; expect_next(0, 0, 6'h01, "R4 bits1:0 ignored");
    fault_in = 6'h00; off_for(T+2, 6'h01, "R4 latched");
    en = 0; expect_next(0, 0, 6'h01, "R10 idle");
    en = 1; expect_next(1, 1, 6'h00, "R5 restart");
    expect_next(1, 0, 6'h00, "R5 run");
    en = 0; expect_next(0, 0, 6'h00, "R10 off from run");

    do_por(1'b0);
    expect_next(0, 0, 6'h00, "R1 reset strap low");
    en = 1; expect_next(1, 1, 6'h00, "R5 soft");
    expect_next(1, 0, 6'h00, "R5 run");
    fault_in = 6'h20; expect_next(0, 0, 6'h20, "R4 top fault latches");
    fault_in = 6'h00; off_for(T+2, 6'h20, "R7 latched");

    do_por(1'b1);
    expect_next(1, 1, 6'h00, "R7 POR clears latch");

    wait (q.size() == 0);
    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule